// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counters of a CAN controller node and applies the confinement rules that move them. A protocol engine drives one-cycle event strobes: error flags, bit errors raised while the node sends an error or overload flag, the first bit after a flag, successful transmission and successful reception. It also drives qualifier bits that select the exemptions. The block watches the bus samples that follow a flag by itself. It counts the run of dominant bits and charges a penalty when the run grows too long.

Both counters are read-only. They appear as separate outputs and also packed into a 32-bit status word. The block decodes the node state from the counters: error-active, error-passive or bus-off. In bus-off the counters hold their values until the protocol engine pulses a clear strobe. Bit timing, frame decoding and the bus-off recovery sequence belong to the surrounding controller.

Top module: `can_fault_counters`

## Requirements
- R1: After a synchronous reset, both counters read 0, the status word reads 0 and the state is error-active.
- R2: `tx_flag` adds 8 to the transmit counter, with two exemptions that add nothing. The first is `tx_arb_stuff` set. The second is `tx_ack_err` set, `tx_dom_seen` clear and the node error-passive. An ACK error in the error-active state is not exempt.
- R3: `tx_flag_bit_err` adds 8 to the transmit counter.
- R4: While `post_flag_win` is high, dominant samples (`bit_sample` with `bit_dom`=1) are counted. The first penalty of 8 comes on the 14th consecutive dominant sample after an active or overload flag (`flag_passive`=0 at `flag_start`). After a passive flag it comes on the 8th. A further 8 follows every 8 more dominant samples. The penalty goes to the transmit counter when `node_is_tx`=1 and to the receive counter otherwise. A recessive sample, a low window or a new `flag_start` restarts the run from the first threshold.
- R5: `tx_ok` lowers the transmit counter by 1 and leaves it at 0 when it is already 0.
- R6: `rx_err` adds 1 to the receive counter unless `rx_err_in_flag` is set, in which case it adds nothing.
- R7: `rx_first_dom` and `rx_flag_bit_err` each add 8 to the receive counter.
- R8: `rx_ok` acts on the receive counter as follows. A value from 1 to 127 goes down by 1. A value of 0 stays 0. A value above 127 becomes exactly 127.
- R9: Additions to the receive counter saturate at 255. The counter never wraps.
- R10: `fc_state` encodes the node state: 2'b10 (bus-off) when the transmit counter is above 255, else 2'b01 (passive) when either counter is 128 or more, else 2'b00 (active).
- R11: In bus-off every counter event is ignored. `clr_counters` sets both counters to 0 in the next cycle.
- R12: Events that arrive in the same cycle combine with the additions first. The success rule is then applied to the sum.
- R13: `status_word` carries the transmit counter in bits 24:16 and the receive counter in bits 7:0. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_counters | input | 1 | Strobe: clear both counters |
| node_is_tx | input | 1 | Node is the transmitter of the current frame |
| tx_flag | input | 1 | Strobe: transmitter signals an error flag |
| tx_ack_err | input | 1 | Qualifier: the flag was caused by an ACK error |
| tx_dom_seen | input | 1 | Qualifier: a dominant bit was seen during the passive flag |
| tx_arb_stuff | input | 1 | Qualifier: stuff error in arbitration on a recessive bit read back dominant |
| tx_flag_bit_err | input | 1 | Strobe: transmitter bit error while sending an active or overload flag |
| rx_err | input | 1 | Strobe: receiver detected an error |
| rx_err_in_flag | input | 1 | Qualifier: that error is a bit error inside an active or overload flag |
| rx_first_dom | input | 1 | Strobe: first bit after the error flag was dominant |
| rx_flag_bit_err | input | 1 | Strobe: receiver bit error while sending an active flag |
| flag_start | input | 1 | Strobe: a new error or overload flag begins |
| flag_passive | input | 1 | Flag kind at `flag_start`: 1 passive, 0 active or overload |
| post_flag_win | input | 1 | Level: dominant-run counting window is open |
| bit_sample | input | 1 | Strobe: a bus bit was sampled |
| bit_dom | input | 1 | Value of the sampled bit, 1 dominant |
| tx_ok | input | 1 | Strobe: successful transmission |
| rx_ok | input | 1 | Strobe: successful reception |
| tec | output | 9 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| fc_state | output | 2 | Node state code |
| status_word | output | 32 | Packed read-only counter word |

## Verification
On every cycle the assertions check these properties: the state code agrees with the counters, bus-off freezes both counters, a clear empties them, a lone success strobe steps or clamps a counter, and the receive counter falls only on a success or clear. The bench scenarios cover what the assertions cannot. They show the exemption choices of the flag penalty, the exact sample on which a dominant-run penalty lands for both flag kinds and after a restart, saturation at 255, and the order in which a same-cycle penalty and success strobe are applied.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;

    // Transmit-side events after exemption filtering
    typedef struct packed {
        logic flag_pen;
        logic bit_err_pen;
        logic run_pen;
        logic ok;
    } tx_evt_t;

    // Receive-side events after exemption filtering
    typedef struct packed {
        logic err_inc;
        logic first_dom_pen;
        logic bit_err_pen;
        logic run_pen;
        logic ok;
    } rx_evt_t;

    localparam int unsigned PEN_STEP    = 8;
    localparam int unsigned PASSIVE_LIM = 128;
    localparam int unsigned BUSOFF_LIM  = 256;
    localparam int unsigned REC_CLAMP   = 127;

    function automatic int unsigned sat_add(input int unsigned v,
                                            input int unsigned a,
                                            input int unsigned lim);
        int unsigned s;
        s = v + a;
        return (s > lim) ? lim : s;
    endfunction

    function automatic int unsigned bit_u(input logic b);
        return b ? 1 : 0;
    endfunction

endpackage

// File: rtl/can_fc_domrun.sv
module can_fc_domrun #(
    parameter int unsigned RUN_W   = 4,
    parameter int unsigned ACT_THR = 14,
    parameter int unsigned PAS_THR = 8,
    parameter int unsigned REP_THR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_start,
    input  logic flag_passive,
    input  logic win,
    input  logic bit_sample,
    input  logic bit_dom,
    output logic run_pen
);
    localparam int unsigned CW = RUN_W + 1;

    logic [RUN_W-1:0] cnt_q;
    logic             rep_q;   // first penalty of this run already charged
    logic             pas_q;   // flag kind latched at flag start
    logic [CW-1:0]    thr;
    logic [CW-1:0]    cnt_inc;

    always_comb begin
        if (rep_q)      thr = CW'(REP_THR);
        else if (pas_q) thr = CW'(PAS_THR);
        else            thr = CW'(ACT_THR);
        cnt_inc = {1'b0, cnt_q} + CW'(1);
        run_pen = win && bit_sample && bit_dom && !flag_start && (cnt_inc == thr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rep_q <= 1'b0;
            pas_q <= 1'b0;
        end else if (flag_start) begin
            cnt_q <= '0;
            rep_q <= 1'b0;
            pas_q <= flag_passive;
        end else if (!win) begin
            cnt_q <= '0;
            rep_q <= 1'b0;
        end else if (bit_sample) begin
            if (!bit_dom) begin
                cnt_q <= '0;
                rep_q <= 1'b0;
            end else if (run_pen) begin
                cnt_q <= '0;
                rep_q <= 1'b1;
            end else begin
                cnt_q <= cnt_inc[RUN_W-1:0];
            end
        end
    end

endmodule

// File: rtl/can_fc_tec.sv
module can_fc_tec
    import can_fc_pkg::*;
#(
    parameter int unsigned TEC_W = 9,
    parameter int unsigned PEN   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             freeze,
    input  tx_evt_t          ev,
    output logic [TEC_W-1:0] tec_q
);
    localparam int unsigned TEC_MAX = (1 << TEC_W) - 1;

    logic [TEC_W-1:0] tec_nxt;

    always_comb begin
        int unsigned add;
        int unsigned sum;
        add = PEN * (bit_u(ev.flag_pen) + bit_u(ev.bit_err_pen) + bit_u(ev.run_pen));
        sum = sat_add(int'(tec_q), add, TEC_MAX);
        if (ev.ok && sum != 0) sum = sum - 1;
        tec_nxt = TEC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   tec_q <= '0;
        else if (!freeze) tec_q <= tec_nxt;
    end

endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec
    import can_fc_pkg::*;
#(
    parameter int unsigned REC_W = 8,
    parameter int unsigned PEN   = 8,
    parameter int unsigned CLAMP = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             freeze,
    input  rx_evt_t          ev,
    output logic [REC_W-1:0] rec_q
);
    localparam int unsigned REC_MAX = (1 << REC_W) - 1;

    logic [REC_W-1:0] rec_nxt;

    always_comb begin
        int unsigned add;
        int unsigned sum;
        add = bit_u(ev.err_inc)
            + PEN * (bit_u(ev.first_dom_pen) + bit_u(ev.bit_err_pen) + bit_u(ev.run_pen));
        sum = sat_add(int'(rec_q), add, REC_MAX);
        if (ev.ok) begin
            if (sum > CLAMP)   sum = CLAMP;
            else if (sum != 0) sum = sum - 1;
        end
        rec_nxt = REC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)   rec_q <= '0;
        else if (!freeze) rec_q <= rec_nxt;
    end

endmodule

// File: rtl/can_fault_counters.sv
module can_fault_counters
    import can_fc_pkg::*;
#(
    parameter int unsigned TEC_W    = 9,
    parameter int unsigned REC_W    = 8,
    parameter int unsigned STATUS_W = 32,
    parameter int unsigned TEC_LSB  = 16,
    parameter int unsigned REC_LSB  = 0,
    parameter int unsigned RUN_W    = 4,
    parameter int unsigned ACT_THR  = 14,
    parameter int unsigned PAS_THR  = 8,
    parameter int unsigned REP_THR  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_counters,
    input  logic                node_is_tx,
    input  logic                tx_flag,
    input  logic                tx_ack_err,
    input  logic                tx_dom_seen,
    input  logic                tx_arb_stuff,
    input  logic                tx_flag_bit_err,
    input  logic                rx_err,
    input  logic                rx_err_in_flag,
    input  logic                rx_first_dom,
    input  logic                rx_flag_bit_err,
    input  logic                flag_start,
    input  logic                flag_passive,
    input  logic                post_flag_win,
    input  logic                bit_sample,
    input  logic                bit_dom,
    input  logic                tx_ok,
    input  logic                rx_ok,
    output logic [TEC_W-1:0]    tec,
    output logic [REC_W-1:0]    rec,
    output logic [1:0]          fc_state,
    output logic [STATUS_W-1:0] status_word
);
    localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
    localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
    localparam logic [REC_W-1:0] REC_PASS = REC_W'(PASSIVE_LIM);

    logic      run_pen;
    logic      err_passive;
    logic      bus_off;
    logic      flag_exempt;
    tx_evt_t   tx_ev;
    rx_evt_t   rx_ev;
    fc_state_e state;

    can_fc_domrun #(
        .RUN_W  (RUN_W),
        .ACT_THR(ACT_THR),
        .PAS_THR(PAS_THR),
        .REP_THR(REP_THR)
    ) u_run (
        .clk         (clk),
        .rst         (rst),
        .flag_start  (flag_start),
        .flag_passive(flag_passive),
        .win         (post_flag_win),
        .bit_sample  (bit_sample),
        .bit_dom     (bit_dom),
        .run_pen     (run_pen)
    );

    // State decode from registered counters
    always_comb begin
        bus_off     = (tec >= TEC_OFF);
        err_passive = (tec >= TEC_PASS) || (rec >= REC_PASS);
        if (bus_off)          state = FC_BUSOFF;
        else if (err_passive) state = FC_PASSIVE;
        else                  state = FC_ACTIVE;
    end

    // Exemption filtering of the raw event strobes
    always_comb begin
        flag_exempt = tx_arb_stuff || (err_passive && tx_ack_err && !tx_dom_seen);

        tx_ev.flag_pen    = tx_flag && !flag_exempt;
        tx_ev.bit_err_pen = tx_flag_bit_err;
        tx_ev.run_pen     = run_pen && node_is_tx;
        tx_ev.ok          = tx_ok;

        rx_ev.err_inc       = rx_err && !rx_err_in_flag;
        rx_ev.first_dom_pen = rx_first_dom;
        rx_ev.bit_err_pen   = rx_flag_bit_err;
        rx_ev.run_pen       = run_pen && !node_is_tx;
        rx_ev.ok            = rx_ok;
    end

    can_fc_tec #(
        .TEC_W(TEC_W),
        .PEN  (PEN_STEP)
    ) u_tec (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_counters),
        .freeze(bus_off),
        .ev    (tx_ev),
        .tec_q (tec)
    );

    can_fc_rec #(
        .REC_W(REC_W),
        .PEN  (PEN_STEP),
        .CLAMP(REC_CLAMP)
    ) u_rec (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_counters),
        .freeze(bus_off),
        .ev    (rx_ev),
        .rec_q (rec)
    );

    assign fc_state = state;

    always_comb begin
        status_word = '0;
        status_word[TEC_LSB +: TEC_W] = tec;
        status_word[REC_LSB +: REC_W] = rec;
    end

endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
    parameter int unsigned TEC_W = 9,
    parameter int unsigned REC_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_counters,
    input logic             tx_flag,
    input logic             tx_flag_bit_err,
    input logic             rx_err,
    input logic             rx_first_dom,
    input logic             rx_flag_bit_err,
    input logic             bit_sample,
    input logic             bit_dom,
    input logic             tx_ok,
    input logic             rx_ok,
    input logic [TEC_W-1:0] tec,
    input logic [REC_W-1:0] rec,
    input logic [1:0]       fc_state
);
    logic dom_s;
    assign dom_s = bit_sample && bit_dom;

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (tec == '0 && rec == '0));

    // R10
    a_r10_busoff_code: assert property (@(posedge clk) disable iff (rst)
        (tec > TEC_W'(255)) |-> (fc_state == 2'b10));

    a_r10_active_code: assert property (@(posedge clk) disable iff (rst)
        (tec < TEC_W'(128) && rec < REC_W'(128)) |-> (fc_state == 2'b00));

    // R11
    a_r11_busoff_frozen: assert property (@(posedge clk) disable iff (rst)
        (fc_state == 2'b10 && !clr_counters) |=> ($stable(tec) && $stable(rec)));

    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        clr_counters |=> (tec == '0 && rec == '0));

    // R5
    a_r5_tx_step: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && !tx_flag && !tx_flag_bit_err && !dom_s && !clr_counters
         && fc_state != 2'b10 && tec != '0) |=> (tec == $past(tec) - TEC_W'(1)));

    // R8
    a_r8_rec_clamp: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && !rx_err && !rx_first_dom && !rx_flag_bit_err && !dom_s
         && !clr_counters && fc_state != 2'b10 && rec > REC_W'(127))
        |=> (rec == REC_W'(127)));

    // R9
    a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clr_counters && !rx_ok) |=> (rec >= $past(rec)));

endmodule

bind can_fault_counters can_fc_checker #(
    .TEC_W(TEC_W),
    .REC_W(REC_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .clr_counters   (clr_counters),
    .tx_flag        (tx_flag),
    .tx_flag_bit_err(tx_flag_bit_err),
    .rx_err         (rx_err),
    .rx_first_dom   (rx_first_dom),
    .rx_flag_bit_err(rx_flag_bit_err),
    .bit_sample     (bit_sample),
    .bit_dom        (bit_dom),
    .tx_ok          (tx_ok),
    .rx_ok          (rx_ok),
    .tec            (tec),
    .rec            (rec),
    .fc_state       (fc_state)
);

// File: tb/sim_can_fault_counters.sv
module sim_can_fault_counters;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_counters, node_is_tx, tx_flag, tx_ack_err, tx_dom_seen, tx_arb_stuff;
    logic tx_flag_bit_err, rx_err, rx_err_in_flag, rx_first_dom, rx_flag_bit_err;
    logic flag_start, flag_passive, post_flag_win, bit_sample, bit_dom, tx_ok, rx_ok;
    logic [8:0]  tec;
    logic [7:0]  rec;
    logic [1:0]  fc_state;
    logic [31:0] status_word;

    int n_chk = 0;
    int n_err = 0;
    int exp_tec = 0;
    int exp_rec = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_fault_counters u0 (
        .clk(clk), .rst(rst), .clr_counters(clr_counters), .node_is_tx(node_is_tx),
        .tx_flag(tx_flag), .tx_ack_err(tx_ack_err), .tx_dom_seen(tx_dom_seen),
        .tx_arb_stuff(tx_arb_stuff), .tx_flag_bit_err(tx_flag_bit_err),
        .rx_err(rx_err), .rx_err_in_flag(rx_err_in_flag), .rx_first_dom(rx_first_dom),
        .rx_flag_bit_err(rx_flag_bit_err), .flag_start(flag_start),
        .flag_passive(flag_passive), .post_flag_win(post_flag_win),
        .bit_sample(bit_sample), .bit_dom(bit_dom), .tx_ok(tx_ok), .rx_ok(rx_ok),
        .tec(tec), .rec(rec), .fc_state(fc_state), .status_word(status_word)
    );

    task automatic clear_in();
        clr_counters = 0; tx_flag = 0; tx_ack_err = 0; tx_dom_seen = 0;
        tx_arb_stuff = 0; tx_flag_bit_err = 0; rx_err = 0; rx_err_in_flag = 0;
        rx_first_dom = 0; rx_flag_bit_err = 0; flag_start = 0; bit_sample = 0;
        bit_dom = 0; tx_ok = 0; rx_ok = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_in();
    endtask

    task automatic dom(input logic d);
        bit_sample = 1; bit_dom = d;
        tick();
    endtask

    task automatic chk(input string req);
        logic [1:0]  es;
        logic [31:0] ew;
        if (exp_tec > 255) es = 2'b10;
        else if (exp_tec >= 128 || exp_rec >= 128) es = 2'b01;
        else es = 2'b00;
        ew = {7'b0, 9'(exp_tec), 8'b0, 8'(exp_rec)};
        n_chk++;
        if (tec != 9'(exp_tec) || rec != 8'(exp_rec) || fc_state != es || status_word != ew) begin
            n_err++;
            $display("FAIL %s: tec=%0d rec=%0d state=%0d word=%h expected tec=%0d rec=%0d state=%0d word=%h",
                     req, tec, rec, fc_state, status_word, exp_tec, exp_rec, es, ew);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        clear_in();
        node_is_tx = 1; flag_passive = 0; post_flag_win = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 R13 reset");

        // R2, R3: transmit flag penalties in error-active state
        tx_flag = 1; tick(); exp_tec = 8; chk("R2 flag adds 8");
        tx_flag = 1; tx_arb_stuff = 1; tick(); chk("R2 arbitration stuff exempt");
        tx_flag = 1; tx_ack_err = 1; tick(); exp_tec = 16; chk("R2 ack error active not exempt");
        tx_flag_bit_err = 1; tick(); exp_tec = 24; chk("R3 bit error in flag");

        // R5: decrement sweep through zero
        for (int i = 0; i < 26; i++) begin
            tx_ok = 1; tick();
            if (exp_tec > 0) exp_tec--;
            chk("R5 tx success");
        end

        // R6
        for (int i = 0; i < 5; i++) begin
            rx_err = 1; tick(); exp_rec++; chk("R6 rx error adds 1");
        end
        rx_err = 1; rx_err_in_flag = 1; tick(); chk("R6 in-flag bit error exempt");

        // R7
        rx_first_dom = 1; tick(); exp_rec += 8; chk("R7 first bit dominant");
        rx_flag_bit_err = 1; tick(); exp_rec += 8; chk("R7 bit error in active flag");

        // R8: decrement sweep through zero
        for (int i = 0; i < 24; i++) begin
            rx_ok = 1; tick();
            if (exp_rec > 0) exp_rec--;
            chk("R8 rx success step");
        end

        // R9, R10: climb to saturation
        for (int i = 0; i < 34; i++) begin
            rx_first_dom = 1; tick();
            exp_rec = (exp_rec + 8 > 255) ? 255 : exp_rec + 8;
            chk("R9 R10 rec saturate");
        end

        // R2 passive exemption
        tx_flag = 1; tx_ack_err = 1; tick(); chk("R2 passive ack quiet exempt");
        tx_flag = 1; tx_ack_err = 1; tx_dom_seen = 1; tick(); exp_tec = 8;
        chk("R2 passive ack with dominant not exempt");

        // R8 clamp
        rx_ok = 1; tick(); exp_rec = 127; chk("R8 clamp to 127");
        rx_ok = 1; tick(); exp_rec = 126; chk("R8 step below clamp");

        // R12 same-cycle ordering
        tx_flag = 1; tx_ok = 1; tick(); exp_tec = 15; chk("R12 tx add then step");
        rx_first_dom = 1; rx_ok = 1; tick(); exp_rec = 127; chk("R12 rx add then clamp");
        rx_err = 1; rx_ok = 1; tick(); exp_rec = 127; chk("R12 rx add 1 then step");

        clr_counters = 1; tick(); exp_tec = 0; exp_rec = 0; chk("R11 clear");

        // R4 active flag, transmitter
        node_is_tx = 1; post_flag_win = 1; flag_passive = 0; flag_start = 1; tick();
        for (int k = 1; k <= 30; k++) begin
            dom(1);
            exp_tec = (k >= 14) ? 8 * (1 + (k - 14) / 8) : 0;
            chk("R4 active run to tec");
        end
        dom(0); chk("R4 recessive restarts");
        for (int k = 1; k <= 14; k++) begin
            dom(1);
            if (k == 14) exp_tec += 8;
            chk("R4 restart needs 14");
        end
        post_flag_win = 0;
        clr_counters = 1; tick(); exp_tec = 0; chk("R11 clear");

        // R4 passive flag, receiver
        node_is_tx = 0; post_flag_win = 1; flag_passive = 1; flag_start = 1; tick();
        for (int k = 0; k < 5; k++) begin dom(1); chk("R4 passive short run"); end
        dom(0); chk("R4 passive recessive");
        for (int k = 1; k <= 24; k++) begin
            dom(1);
            exp_rec = 8 * (k / 8);
            chk("R4 passive run to rec");
        end
        post_flag_win = 0;
        for (int k = 0; k < 20; k++) begin dom(1); chk("R4 window closed"); end
        node_is_tx = 1;

        // R11 bus-off
        clr_counters = 1; tick(); exp_tec = 0; exp_rec = 0; chk("R11 clear");
        for (int i = 0; i < 32; i++) begin
            tx_flag_bit_err = 1; tick(); exp_tec += 8; chk("R11 R10 climb to bus-off");
        end
        tx_ok = 1; tick(); chk("R11 tx success ignored in bus-off");
        rx_err = 1; rx_first_dom = 1; tick(); chk("R11 rx errors ignored in bus-off");
        tx_flag = 1; tick(); chk("R11 flag ignored in bus-off");
        clr_counters = 1; tick(); exp_tec = 0; exp_rec = 0; chk("R11 R1 clear from bus-off");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule